// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the interrupt status and interrupt enable state of a real-time clock. Two event pulses come in from elsewhere in the clock: one when the alarm time matches, one when an update cycle completes. Each pulse sets a sticky flag in the status register. The control register holds an enable bit for each source. When a set flag meets its enable, the active-low open-drain request line `irq_n` is pulled low and bit 7 of the status register reports the pending request.

The host reaches both registers through a small single-cycle bus. A read of the status register returns the flags and clears all of them, together with the summary bit. The request line releases at the next clock edge. An event that arrives in the same cycle as that read is kept for the next read. The reset input clears the enables and the flags and releases the line at once. Nothing inside the block ever changes an enable.

The request line is driven by a two-state machine. `LINE_QUIET` means no enabled flag is pending and `irq_n` is released (high). `LINE_ACTIVE` means at least one enabled flag is pending and `irq_n` is driven low. Transition `T_RAISE` (QUIET to ACTIVE) is taken when an enabled flag will be set after the coming edge. This happens after an enabled event, or after a control write that enables a source whose flag is already set. Transition `T_RELEASE` (ACTIVE to QUIET) is taken when no enabled flag will remain. This happens after a status read, after a control write that removes the enables, or on reset. In every other case the state holds: `T_HOLD_QUIET` and `T_HOLD_ACTIVE`.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and both registers read 0x00.
- R2: A write with `bus_cs`=1, `bus_we`=1, `bus_addr`=0 loads the control register. Bit 5 is the alarm enable and bit 4 is the update enable. A read of address 0 returns those two bits in place, and every other bit reads 0.
- R3: An `alarm_evt` pulse sets the alarm flag, which is bit 5 of the status register (address 1). This happens whether the alarm enable is set or not.
- R4: An `update_evt` pulse sets the update flag, which is bit 4 of the status register. This happens whether the update enable is set or not.
- R5: When (alarm flag AND alarm enable) OR (update flag AND update enable) holds, `irq_n` is 0 and status bit 7 reads 1. Both follow one clock edge after the event or write that causes the condition.
- R6: A flag whose enable is 0 does not pull `irq_n` low and does not set status bit 7.
- R7: A read of address 1 returns the flags as they were before that read. At the clock edge ending the read, all flags and bit 7 clear and `irq_n` returns to 1.
- R8: An event pulse in the same cycle as a status read is not shown in that read. It is held and shown by the next status read.
- R9: Flags stay set until a status read or reset. Control reads and control writes do not clear them, writes to address 1 have no effect, and enabling a source whose flag is already set pulls `irq_n` low one edge after the write.
- R10: Asserting `rst_n` low at any time releases `irq_n` at once and clears all enables and flags.
- R11: Event pulses and status reads never change the enable bits. Only control writes and reset do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears enables and flags |
| bus_cs | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| alarm_evt | input | 1 | One-cycle alarm match pulse |
| update_evt | input | 1 | One-cycle update-ended pulse |
| irq_n | output | 1 | Active-low open-drain interrupt request (1 = released) |

## Verification
Flags, enables and the request line all change at the first clock edge after the event pulse or control write that causes them. The bench therefore drives each stimulus for one cycle from a falling edge and samples `irq_n` and read data at the following falling edge. Read data is combinational, so a status read is sampled while the strobe is still high, before the clearing edge. The release of `irq_n` and the cleared status are checked one cycle later. Reset acts without a clock edge, so the bench checks `irq_n` a fraction of a cycle after pulling `rst_n` low.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_SRC    = 2;
    // source i lives at bit SRC_BASE+i in both the control and status registers
    localparam int SRC_BASE   = 4;
    localparam int SRC_UPDATE = 0;
    localparam int SRC_ALARM  = 1;
    localparam int BIT_SUMMARY = 7;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;
endpackage

// File: rtl/rtc_irq_enables.sv
`timescale 1ns/1ps
module rtc_irq_enables #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] en_nxt
);
    always_comb begin
        en_nxt = wr_stb ? wr_bits : en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en <= '0;
        else        en <= en_nxt;
    end

    // R11: only a control write may move the enables
    a_r11_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(en));
endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flg,
    output logic [NUM_SRC-1:0] flg_nxt
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_comb begin
            flg_nxt[i] = evt[i] | (flg[i] & ~clr);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flg[i] <= 1'b0;
            else        flg[i] <= flg_nxt[i];
        end

        // R8: a pulse always lands, even beside a clearing read
        a_r8_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flg[i]);
        // R7: a read with no new pulse empties the flag
        a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[i]) |=> !flg[i]);
        // R9: without a read the flag persists
        a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flg[i] && !clr) |=> flg[i]);
    end
endmodule

// File: rtl/rtc_irq_line.sv
`timescale 1ns/1ps
module rtc_irq_line
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt,
    output logic irq_n,
    output logic summary
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pend_nxt)  state_d = LINE_ACTIVE; // T_RAISE
            LINE_ACTIVE: if (!pend_nxt) state_d = LINE_QUIET;  // T_RELEASE
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n   = 1'b1;
        summary = 1'b0;
        unique case (state_q)
            LINE_QUIET: begin
                irq_n   = 1'b1;
                summary = 1'b0;
            end
            LINE_ACTIVE: begin
                irq_n   = 1'b0;
                summary = 1'b1;
            end
            default: begin
                irq_n   = 1'b1;
                summary = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              alarm_evt,
    input  logic              update_evt,
    output logic              irq_n
);
    localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'(((1 << NUM_SRC) - 1) << SRC_BASE);

    logic               wr_ctrl, rd_stat;
    logic [NUM_SRC-1:0] en, en_nxt, flg, flg_nxt, evt;
    logic               pend_nxt, summary;
    logic               unused_wdata;

    assign wr_ctrl = bus_cs && bus_we && (bus_addr == ADDR_CTRL);
    assign rd_stat = bus_cs && !bus_we && (bus_addr == ADDR_STAT);
    assign unused_wdata = ^(bus_wdata & ~SRC_MASK);

    always_comb begin
        evt             = '0;
        evt[SRC_UPDATE] = update_evt;
        evt[SRC_ALARM]  = alarm_evt;
    end

    rtc_irq_enables #(.NUM_SRC(NUM_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_ctrl),
        .wr_bits (bus_wdata[SRC_BASE +: NUM_SRC]),
        .en      (en),
        .en_nxt  (en_nxt)
    );

    rtc_irq_flags #(.NUM_SRC(NUM_SRC)) u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clr     (rd_stat),
        .flg     (flg),
        .flg_nxt (flg_nxt)
    );

    assign pend_nxt = |(flg_nxt & en_nxt);

    rtc_irq_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_nxt),
        .irq_n    (irq_n),
        .summary  (summary)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_cs && !bus_we) begin
            if (bus_addr == ADDR_STAT) begin
                bus_rdata[SRC_BASE +: NUM_SRC] = flg;
                bus_rdata[BIT_SUMMARY]         = summary;
            end else begin
                bus_rdata[SRC_BASE +: NUM_SRC] = en;
            end
        end
    end

    // R5: an enabled pending flag holds the line low
    a_r5_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flg & en)) |-> !irq_n);
    // R6: with no enabled pending flag the line stays released
    a_r6_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flg & en)) |-> irq_n);
    // R7: the line is released after a read with no new event
    a_r7_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !alarm_evt && !update_evt) |=> irq_n);
endmodule

// File: tb/rtc_irq_ctrl_test.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_evt = 1'b0, update_evt = 1'b0;
    logic       irq_n;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    rtc_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_evt(alarm_evt), .update_evt(update_evt), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, input logic alm, input logic upd, output logic [7:0] q);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        alarm_evt = alm; update_evt = upd;
        #1 q = bus_rdata;
        cyc();
        bus_cs = 1'b0; alarm_evt = 1'b0; update_evt = 1'b0;
    endtask

    task automatic pulse(input logic alm, input logic upd);
        alarm_evt = alm; update_evt = upd;
        cyc();
        alarm_evt = 1'b0; update_evt = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q;
        cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        check("R1 irq_n", irq_n, 1);
        rd(1'b0, 0, 0, q); check("R1 ctrl", q, 0);
        rd(1'b1, 0, 0, q); check("R1 stat", q, 0);

        // Sweep every enable pair against every event pair
        for (int ae = 0; ae < 2; ae++)
        for (int ue = 0; ue < 2; ue++)
        for (int a = 0; a < 2; a++)
        for (int u = 0; u < 2; u++) begin
            int pend;
            do_reset();
            wr(1'b0, 8'hCF | 8'(ae << 5) | 8'(ue << 4));
            rd(1'b0, 0, 0, q);
            check("R2 ctrl readback", q, (ae << 5) | (ue << 4));
            pulse(a[0], u[0]);
            pend = (a & ae) | (u & ue);
            check("R5/R6 irq_n after event", irq_n, pend ? 0 : 1);
            rd(1'b1, 0, 0, q);
            check("R3/R4/R5 stat", q, (pend << 7) | (a << 5) | (u << 4));
            check("R7 irq_n released", irq_n, 1);
            rd(1'b1, 0, 0, q);
            check("R7 stat cleared", q, 0);
            rd(1'b0, 0, 0, q);
            check("R11 ctrl unchanged", q, (ae << 5) | (ue << 4));
        end

        // R9: sticky flag, ignored status write, late enable
        do_reset();
        pulse(1'b0, 1'b1);
        check("R6 masked update", irq_n, 1);
        wr(1'b1, 8'hFF);
        rd(1'b0, 0, 0, q); check("R9 ctrl after stat write", q, 0);
        wr(1'b0, 8'h10);
        check("R9 late enable raises", irq_n, 0);
        rd(1'b1, 0, 0, q); check("R9 stat kept", q, 8'h90);
        check("R7 release", irq_n, 1);

        // R8: event beside a status read
        do_reset();
        wr(1'b0, 8'h20);
        pulse(1'b1, 1'b0);
        check("R5 alarm raises", irq_n, 0);
        rd(1'b1, 1, 0, q); check("R8 read before new event", q, 8'hA0);
        check("R8 line stays low", irq_n, 0);
        rd(1'b1, 0, 0, q); check("R8 event kept", q, 8'hA0);
        check("R8 release", irq_n, 1);

        // R10: reset in the middle of an active request
        wr(1'b0, 8'h30);
        pulse(1'b1, 1'b1);
        check("R5 both raise", irq_n, 0);
        rst_n = 1'b0;
        #1 check("R10 async release", irq_n, 1);
        cyc();
        rst_n = 1'b1;
        cyc();
        rd(1'b0, 0, 0, q); check("R10 enables cleared", q, 0);
        rd(1'b1, 0, 0, q); check("R10 flags cleared", q, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule